// File: doc/BRIEF.md
# Banked External Interrupt Controller

This block watches 32 external interrupt pins, arranged as four banks of eight lines, and turns each pin into a latched interrupt request. Every line has its own trigger setting: either edge, both edges, or a level of either polarity. Each line also has a mask bit. A detected event sets the line's pending flag, and software clears that flag by writing a one to it.

Lines 0 to 15 each drive a dedicated request output. Lines 16 to 31 share a single request output, which is high whenever any of them is pending and not masked. Software reaches the configuration, mask and pending words of each bank through a small word-addressed register port. The port has a single-cycle write strobe and a combinational read.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0, every mask word reads 0x000000FF (all lines blocked), every pending word reads 0, and all request outputs are low.
- R2: Configuration words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C, mask words at 0x10 to 0x1C, and pending words at 0x20 to 0x2C, one per bank. Line n uses bank n>>3 and bit n&7. Its trigger code is the 3-bit field at bit 4*(n&7) of the configuration word. Every other configuration bit, mask bits above 7, and offsets 0x30 to 0x3C all read 0.
- R3: With code 3'b011, a low-to-high transition of the pin sets the pending bit. A steady level or a falling transition does not set it.
- R4: With code 3'b010, only a high-to-low transition sets the pending bit.
- R5: With code 3'b100, either transition sets the pending bit.
- R6: With code 3'b001 (high) or 3'b000 (low), the pending bit is set on every cycle the pin sits at the active level. A clear written while that level persists leaves the bit at 1.
- R7: Codes 3'b101, 3'b110 and 3'b111 never set the pending bit.
- R8: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. Once set, a pending bit stays set until it is cleared.
- R9: When a detected event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: For lines 0 to 15, output irq_line[n] equals pending bit n AND NOT mask bit n. Masking hides the request without changing the pending bit.
- R11: irq_shared is high exactly when at least one of lines 16 to 31 is pending and unmasked.
- R12: Pins pass through a two-flop synchroniser. A pin change made before clock edge k shows in the pending bit after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 32 | External interrupt pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_line | output | 16 | Dedicated requests for lines 0 to 15 |
| irq_shared | output | 1 | Combined request for lines 16 to 31 |

## Verification
A corrupted pending flag shows up on a request output in the same cycle. Reading its pending word shows it at once. An event that is lost, or a clear that fails to take, shows on the very next pending read. A wrong trigger decode or a slip in the synchroniser depth sets or withholds a pending bit three edges after a pin change. Sweeping every line through every trigger code, with rise, hold and fall phases, exposes such faults within a few cycles of the pin change.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CFG_W  = 3;
  localparam int STRIDE = 4;

  localparam logic [1:0] GRP_CFG  = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_PEND = 2'd2;

  typedef enum logic [CFG_W-1:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b011,
    TRIG_BOTH = 3'b100
  } trig_e;

  // Event on one line from its trigger code, current and previous sample.
  function automatic logic trig_hit(logic [CFG_W-1:0] code, logic cur, logic prev);
    case (code)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_FALL: return prev && !cur;
      TRIG_RISE: return !prev && cur;
      TRIG_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  // Two synchroniser stages, then one history stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= d;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/extint_bank.sv
module extint_bank import extint_pkg::*; #(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cur,
  input  logic [LANES-1:0] prev,
  input  logic             wr_cfg,
  input  logic             wr_mask,
  input  logic             wr_pend,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cfg_word,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] pend_q,
  output logic [LANES-1:0] hit,
  output logic [LANES-1:0] clr
);
  logic [LANES-1:0][CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      for (int i = 0; i < LANES; i++) cfg_q[i] <= wdata[i*STRIDE +: CFG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= wdata[LANES-1:0];
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign hit[g] = trig_hit(cfg_q[g], cur[g], prev[g]);
    end
  endgenerate

  assign clr = wr_pend ? wdata[LANES-1:0] : '0;

  // A set wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | hit;
  end

  always_comb begin
    cfg_word = '0;
    for (int i = 0; i < LANES; i++) cfg_word[i*STRIDE +: CFG_W] = cfg_q[i];
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl import extint_pkg::*; #(
  parameter  int NBANK   = 4,   // at least 2
  parameter  int LANES   = 8,
  parameter  int NDIRECT = 16,
  parameter  int DW      = 32,
  localparam int NLINE   = NBANK * LANES,
  localparam int BW      = $clog2(NBANK),
  localparam int AW      = BW + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NLINE-1:0]   pins,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [NDIRECT-1:0] irq_line,
  output logic               irq_shared
);
  logic [BW-1:0] sel_bank;
  logic [1:0]    sel_grp;
  assign sel_bank = reg_addr[2 +: BW];
  assign sel_grp  = reg_addr[2+BW +: 2];

  logic [NLINE-1:0] cur_vec, prev_vec;
  logic [NLINE-1:0] hit_vec, clr_vec, pend_q, mask_q;
  logic [NBANK-1:0][DW-1:0] cfg_words;

  extint_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .cur(cur_vec), .prev(prev_vec)
  );

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      logic sel;
      assign sel = reg_wr && (sel_bank == BW'(b));
      extint_bank #(.LANES(LANES), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (cur_vec[b*LANES +: LANES]),
        .prev    (prev_vec[b*LANES +: LANES]),
        .wr_cfg  (sel && sel_grp == GRP_CFG),
        .wr_mask (sel && sel_grp == GRP_MASK),
        .wr_pend (sel && sel_grp == GRP_PEND),
        .wdata   (reg_wdata),
        .cfg_word(cfg_words[b]),
        .mask_q  (mask_q[b*LANES +: LANES]),
        .pend_q  (pend_q[b*LANES +: LANES]),
        .hit     (hit_vec[b*LANES +: LANES]),
        .clr     (clr_vec[b*LANES +: LANES])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (sel_grp)
      GRP_CFG:  reg_rdata = cfg_words[sel_bank];
      GRP_MASK: reg_rdata[LANES-1:0] = mask_q[sel_bank*LANES +: LANES];
      GRP_PEND: reg_rdata[LANES-1:0] = pend_q[sel_bank*LANES +: LANES];
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_line   = pend_q[NDIRECT-1:0] & ~mask_q[NDIRECT-1:0];
  assign irq_shared = |(pend_q[NLINE-1:NDIRECT] & ~mask_q[NLINE-1:NDIRECT]);
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int NLINE   = 32,
  parameter int NDIRECT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NLINE-1:0]   hit_vec,
  input logic [NLINE-1:0]   clr_vec,
  input logic [NLINE-1:0]   pend_q,
  input logic [NDIRECT-1:0] irq_line,
  input logic               irq_shared
);
  // R9: an event always leaves its pending bit set, clear or not.
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(hit_vec)) == $past(hit_vec)));

  // R8: a pending bit without a clear holds.
  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

  // R8: a clear with no event drops the bit.
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec & ~hit_vec)) == '0));

  // R3: a pending bit only rises after a detected event.
  assert_rise_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit_vec)) == '0));

  // R1: first cycle out of reset shows no request.
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (irq_line == '0 && !irq_shared));
endmodule

bind extint_ctrl extint_ctrl_chk #(.NLINE(NLINE), .NDIRECT(NDIRECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .clr_vec(clr_vec),
  .pend_q(pend_q), .irq_line(irq_line), .irq_shared(irq_shared)
);

// File: tb/tb_extint_ctrl.sv
`timescale 1ns/1ps
module tb_extint_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pins = '0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_line;
  logic        irq_shared;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  extint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line),
    .irq_shared(irq_shared)
  );

  function automatic bit model_hit(int code, bit cur, bit prev);
    case (code)
      0: return !cur;
      1: return cur;
      2: return prev && !cur;
      3: return !prev && cur;
      4: return prev != cur;
      default: return 0;
    endcase
  endfunction

  function automatic string code_tag(int code);
    case (code)
      0, 1: return "R6";
      2: return "R4";
      3: return "R3";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_line(input string tag, input int line, input bit exp);
    logic [31:0] v;
    rd(6'h20 + 6'(4*(line >> 3)), v);
    check(tag, {31'b0, v[line & 7]}, {31'b0, exp});
    check("R10", {16'b0, irq_line}, (line < 16 && exp) ? (32'h1 << line) : 32'h0);
    check("R11", {31'b0, irq_shared}, {31'b0, (line >= 16) && exp});
  endtask

  task automatic run_line(input int line, input int code);
    int b = line >> 3;
    int k = line & 7;
    logic [31:0] w, v;
    bit exp;
    string tag = code_tag(code);
    for (int i = 0; i < 4; i++) wr(6'(4*i), 32'h7777_7777);
    w = (32'h7777_7777 & ~(32'hF << (4*k))) | (32'(code) << (4*k));
    wr(6'(4*b), w);
    for (int i = 0; i < 4; i++) wr(6'h10 + 6'(4*i), 32'h0);
    idle(4);
    for (int i = 0; i < 4; i++) wr(6'h20 + 6'(4*i), 32'hFF);
    // phase A: pin low and settled; low-level mode re-sets over the clear (R9)
    exp = model_hit(code, 0, 0);
    check_line((code == 0) ? "R9" : tag, line, exp);
    // phase B: rise then hold high
    pins[line] = 1'b1;
    idle(5);
    exp = exp | model_hit(code, 1, 0) | model_hit(code, 1, 1);
    check_line(tag, line, exp);
    // masking hides the request, pending bit kept
    wr(6'h10 + 6'(4*b), 32'h1 << k);
    rd(6'h20 + 6'(4*b), v);
    check("R10", {31'b0, v[k]}, {31'b0, exp});
    check("R11", {15'b0, irq_shared, irq_line}, 32'h0);
    wr(6'h10 + 6'(4*b), 32'h0);
    // clear while high: only high-level survives
    wr(6'h20 + 6'(4*b), 32'h1 << k);
    exp = model_hit(code, 1, 1);
    check_line((code == 1) ? "R9" : "R8", line, exp);
    // phase C: fall then hold low
    pins[line] = 1'b0;
    idle(5);
    exp = exp | model_hit(code, 0, 1) | model_hit(code, 0, 0);
    check_line(tag, line, exp);
    // writing zeros leaves pending untouched
    wr(6'h20 + 6'(4*b), 32'h0);
    check_line("R8", line, exp);
    wr(6'h20 + 6'(4*b), 32'h1 << k);
    check_line("R8", line, model_hit(code, 0, 0));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    // R1: pending zero before the first edge after release
    for (int i = 0; i < 4; i++) begin
      rd(6'h20 + 6'(4*i), v); check("R1", v, 32'h0);
    end
    check("R1", {15'b0, irq_shared, irq_line}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(6'(4*i), v);        check("R1", v, 32'h0);
      rd(6'h10 + 6'(4*i), v); check("R1", v, 32'h0000_00FF);
    end
    idle(6);
    // reset config is low-level with pins low, yet all masked: no request
    check("R10", {15'b0, irq_shared, irq_line}, 32'h0);
    rd(6'h20, v); check("R6", v, 32'h0000_00FF);

    // R2: field layout and unused bits
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); check("R2", v, 32'h7777_7777);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, v); check("R2", v, 32'h0000_00FF);
    for (int i = 0; i < 4; i++) begin
      rd(6'h30 + 6'(4*i), v); check("R2", v, 32'h0);
    end

    // R12: latency through synchroniser, line 3 rising
    for (int i = 0; i < 4; i++) wr(6'(4*i), 32'h7777_7777);
    wr(6'h00, 32'h7777_3777);
    wr(6'h10, 32'h0);
    wr(6'h20, 32'hFF);
    pins[3] = 1'b1;
    idle(2);
    rd(6'h20, v); check("R12", {31'b0, v[3]}, 32'h0);
    idle(1);
    rd(6'h20, v); check("R12", {31'b0, v[3]}, 32'h1);
    check("R10", {16'b0, irq_line}, 32'h8);
    pins[3] = 1'b0;
    idle(4);

    for (int line = 0; line < 32; line++)
      for (int code = 0; code < 8; code++)
        run_line(line, code);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule